// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block watches the stream of memory requests from several hardware contexts and decides, for every store, whether it may reach memory. A load-linked request leaves a reservation: the address with its low granule bits cleared, tagged with the context that issued it. A later store-conditional from that context writes only if the reservation is still there. The table is indexed by context, so each context holds at most one reservation.

Every store checks the table and removes any reservation on its granule, whatever context owns it. This applies to ordinary stores, to successful store-conditionals and to failed ones. A store-conditional issued while no reservation is held fails at once with result 0. An ordinary store is always allowed to write.

One request is accepted per cycle. The decision is registered and appears on the response outputs on the next clock edge. The memory array itself sits outside this block and takes its write enable from `resp_wr_en`.

Top module: `llsc_monitor`

## Requirements
- R1: A synchronous active-high reset invalidates every reservation and clears all response outputs. A store-conditional issued after reset fails, even if a load-linked was made before the reset.
- R2: Addresses are matched at a 16-byte granule (the low GRAN_BITS=4 bits are cleared). A store-conditional to any byte of the reserved granule matches. An address in the next granule does not match.
- R3: A load-linked (op code 1) records the masked address for the requesting context. A following store-conditional (op code 3) from that context to that granule returns resp_wr_en=1 and resp_sc_ok=1.
- R4: A store-conditional issued while no reservation is held returns resp_wr_en=0 and resp_sc_ok=0.
- R5: An ordinary store (op code 2) always returns resp_wr_en=1, whether or not any reservations are held.
- R6: Every store, plain or conditional, clears the reservations of all contexts on its granule. A later store-conditional to that granule fails.
- R7: A store-conditional fails when the requesting context holds no reservation on that granule, even if another context does. The failed store-conditional still clears the other context's matching reservation.
- R8: A new load-linked from a context replaces that context's earlier reservation. A store-conditional to the old granule then fails.
- R9: Loads (op code 0) and load-linked requests never assert resp_wr_en. A plain load leaves the table unchanged.
- R10: Responses are registered: resp_valid, resp_wr_en, resp_sc and resp_sc_ok reflect the request of the previous cycle, and all are 0 after a cycle with req_valid=0.
- R11: A store to a different granule leaves existing reservations intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 load, 1 load-linked, 2 store, 3 store-conditional |
| req_addr | input | ADDR_W | Physical byte address |
| req_ctx | input | CTX_W | Requesting hardware context |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_wr_en | output | 1 | Store may be written to memory |
| resp_sc | output | 1 | Response belongs to a store-conditional |
| resp_sc_ok | output | 1 | Store-conditional result value (1 success, 0 failure) |

## Verification
A reservation that is wrongly kept or wrongly dropped cannot be seen until a store-conditional probes it. The stimulus therefore follows each load-linked and each clearing store with a store-conditional from the owning context, and one from a non-owning context. These fault-revealing store-conditionals show the fault on resp_sc_ok one cycle after they are issued. A wrong granule mask is exposed by probes at the far end of the reserved granule and at the first byte of the next granule. A wrong entry index is exposed by probes from other contexts. Decode errors in the op code show up directly as resp_wr_en on loads or stores, with the same one-cycle latency.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_LL    = 2'd1,
    OP_STORE = 2'd2,
    OP_SC    = 2'd3
  } llsc_op_e;
endpackage

// File: rtl/llsc_entry.sv
// One reservation slot, owned by the context whose number equals SLOT.
module llsc_entry #(
  parameter int ADDR_W = 32,
  parameter int CTX_W  = 2,
  parameter int SLOT   = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_i,
  input  logic [ADDR_W-1:0] set_addr_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] clr_addr_i,
  output logic              vld_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CTX_W-1:0]  owner_o
);
  localparam logic [CTX_W-1:0] OWNER = CTX_W'(SLOT);

  logic              vld_q;
  logic [ADDR_W-1:0] addr_q;
  logic              hit;

  assign hit = vld_q && (addr_q == clr_addr_i);

  // A load-linked and a store never share a cycle on the single request
  // path, so set and clear are mutually exclusive in practice. Set is
  // listed first only to make the update total.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else if (set_i) begin
      vld_q  <= 1'b1;
      addr_q <= set_addr_i;
    end else if (clr_i && hit) begin
      vld_q  <= 1'b0;
    end
  end

  assign vld_o   = vld_q;
  assign addr_o  = addr_q;
  assign owner_o = OWNER;

  // R3 / R8: a load-linked leaves this slot holding exactly its address
  assert_slot_load_R3: assert property (@(posedge clk) disable iff (rst)
    set_i |=> (vld_o && addr_o == $past(set_addr_i)));

  // R6: a store on the held granule empties the slot
  assert_slot_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i && vld_o && addr_o == clr_addr_i) |=> !vld_o);

  // R11: a store elsewhere leaves the slot untouched
  assert_slot_keep_R11: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i && vld_o && addr_o != clr_addr_i) |=> (vld_o && $stable(addr_o)));
endmodule

// File: rtl/llsc_decide.sv
// Combinational decision for one request against the reservation table.
module llsc_decide
  import llsc_pkg::*;
#(
  parameter int NCTX   = 4,
  parameter int ADDR_W = 32,
  parameter int CTX_W  = 2
) (
  input  logic                        req_valid,
  input  logic [1:0]                  req_op,
  input  logic [ADDR_W-1:0]           gran_addr,
  input  logic [CTX_W-1:0]            req_ctx,
  input  logic [NCTX-1:0]             tbl_vld,
  input  logic [NCTX-1:0][ADDR_W-1:0] tbl_addr,
  input  logic [NCTX-1:0][CTX_W-1:0]  tbl_owner,
  output logic [NCTX-1:0]             set_vec,
  output logic                        clr_o,
  output logic                        wr_en,
  output logic                        is_sc,
  output logic                        sc_ok
);
  llsc_op_e op;
  logic     is_store;
  logic     is_ll;
  logic     any_held;
  logic     own_hit;

  assign op       = llsc_op_e'(req_op);
  assign is_store = req_valid && (op == OP_STORE);
  assign is_ll    = req_valid && (op == OP_LL);
  assign is_sc    = req_valid && (op == OP_SC);
  assign any_held = |tbl_vld;

  always_comb begin
    own_hit = 1'b0;
    for (int i = 0; i < NCTX; i++) begin
      if (tbl_vld[i] && tbl_owner[i] == req_ctx && tbl_addr[i] == gran_addr)
        own_hit = 1'b1;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NCTX; g++) begin : g_set
      assign set_vec[g] = is_ll && (req_ctx == CTX_W'(g));
    end
  endgenerate

  // Empty table: a store-conditional fails without searching.
  assign sc_ok = is_sc && any_held && own_hit;
  assign wr_en = is_store || sc_ok;
  assign clr_o = is_store || is_sc;
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NCTX      = 4,
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 4,
  parameter int CTX_W     = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CTX_W-1:0]  req_ctx,
  output logic              resp_valid,
  output logic              resp_wr_en,
  output logic              resp_sc,
  output logic              resp_sc_ok
);
  localparam logic [ADDR_W-1:0] GRAN_MASK = ~((ADDR_W'(1) << GRAN_BITS) - ADDR_W'(1));

  logic [ADDR_W-1:0]           gran_addr;
  logic [NCTX-1:0]             tbl_vld;
  logic [NCTX-1:0][ADDR_W-1:0] tbl_addr;
  logic [NCTX-1:0][CTX_W-1:0]  tbl_owner;
  logic [NCTX-1:0]             set_vec;
  logic                        clr;
  logic                        d_wr_en;
  logic                        d_is_sc;
  logic                        d_sc_ok;

  assign gran_addr = req_addr & GRAN_MASK;

  genvar s;
  generate
    for (s = 0; s < NCTX; s++) begin : g_slot
      llsc_entry #(.ADDR_W(ADDR_W), .CTX_W(CTX_W), .SLOT(s)) u_entry (
        .clk        (clk),
        .rst        (rst),
        .set_i      (set_vec[s]),
        .set_addr_i (gran_addr),
        .clr_i      (clr),
        .clr_addr_i (gran_addr),
        .vld_o      (tbl_vld[s]),
        .addr_o     (tbl_addr[s]),
        .owner_o    (tbl_owner[s])
      );
    end
  endgenerate

  llsc_decide #(.NCTX(NCTX), .ADDR_W(ADDR_W), .CTX_W(CTX_W)) u_decide (
    .req_valid (req_valid),
    .req_op    (req_op),
    .gran_addr (gran_addr),
    .req_ctx   (req_ctx),
    .tbl_vld   (tbl_vld),
    .tbl_addr  (tbl_addr),
    .tbl_owner (tbl_owner),
    .set_vec   (set_vec),
    .clr_o     (clr),
    .wr_en     (d_wr_en),
    .is_sc     (d_is_sc),
    .sc_ok     (d_sc_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_wr_en <= 1'b0;
      resp_sc    <= 1'b0;
      resp_sc_ok <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      resp_wr_en <= d_wr_en;
      resp_sc    <= d_is_sc;
      resp_sc_ok <= d_sc_ok;
    end
  end

  // R4: store-conditional against an empty table fails
  assert_empty_sc_fails_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'd3 && tbl_vld == '0) |=> (resp_sc && !resp_sc_ok && !resp_wr_en));

  // R5: a plain store is always written
  assert_store_writes_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'd2) |=> resp_wr_en);

  // R9: loads and load-linked never write
  assert_load_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op[1] == 1'b0) |=> !resp_wr_en);

  // R10: an idle cycle gives an empty response
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!resp_valid && !resp_wr_en && !resp_sc && !resp_sc_ok));

  // R3: a load-linked leaves its context holding a reservation
  assert_ll_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'd1) |=> (tbl_vld != '0));
endmodule

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
  localparam int NV = 23;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_ctx = '0;
  logic        resp_valid, resp_wr_en, resp_sc, resp_sc_ok;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  llsc_monitor dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_ctx(req_ctx), .resp_valid(resp_valid),
    .resp_wr_en(resp_wr_en), .resp_sc(resp_sc), .resp_sc_ok(resp_sc_ok)
  );

  // vector: {op[1:0], addr[31:0], ctx[1:0], exp_wr, exp_ok, req_tag[7:0]}
  localparam logic [45:0] VEC [NV] = '{
    {2'd3, 32'h0000_0100, 2'd0, 1'b0, 1'b0, 8'd4},  // R4 empty table
    {2'd2, 32'h0000_0100, 2'd1, 1'b1, 1'b0, 8'd5},  // R5 store, empty table
    {2'd1, 32'h0000_0100, 2'd0, 1'b0, 1'b0, 8'd9},  // R9 load-linked no write
    {2'd3, 32'h0000_010C, 2'd0, 1'b1, 1'b1, 8'd2},  // R2/R3 same granule
    {2'd3, 32'h0000_0100, 2'd0, 1'b0, 1'b0, 8'd6},  // R6 cleared by own SC
    {2'd1, 32'h0000_0200, 2'd1, 1'b0, 1'b0, 8'd3},  // R3
    {2'd1, 32'h0000_0200, 2'd2, 1'b0, 1'b0, 8'd3},  // R3
    {2'd2, 32'h0000_0204, 2'd3, 1'b1, 1'b0, 8'd6},  // R6 clears both
    {2'd3, 32'h0000_0200, 2'd1, 1'b0, 1'b0, 8'd6},  // R6
    {2'd3, 32'h0000_0200, 2'd2, 1'b0, 1'b0, 8'd6},  // R6
    {2'd1, 32'h0000_0300, 2'd0, 1'b0, 1'b0, 8'd3},  // R3
    {2'd1, 32'h0000_0400, 2'd1, 1'b0, 1'b0, 8'd3},  // R3
    {2'd2, 32'h0000_0500, 2'd2, 1'b1, 1'b0, 8'd11}, // R11 other granule
    {2'd0, 32'h0000_0300, 2'd3, 1'b0, 1'b0, 8'd9},  // R9 plain load
    {2'd3, 32'h0000_0300, 2'd1, 1'b0, 1'b0, 8'd7},  // R7 wrong context
    {2'd3, 32'h0000_0300, 2'd0, 1'b0, 1'b0, 8'd7},  // R7 cleared by failed SC
    {2'd1, 32'h0000_0600, 2'd1, 1'b0, 1'b0, 8'd8},  // R8 replaces 0x400
    {2'd3, 32'h0000_0400, 2'd1, 1'b0, 1'b0, 8'd8},  // R8 old granule fails
    {2'd3, 32'h0000_0610, 2'd1, 1'b0, 1'b0, 8'd2},  // R2 next granule
    {2'd3, 32'h0000_060F, 2'd1, 1'b1, 1'b1, 8'd11}, // R11/R2 survived
    {2'd1, 32'h0000_0700, 2'd3, 1'b0, 1'b0, 8'd3},  // R3
    {2'd0, 32'h0000_0700, 2'd2, 1'b0, 1'b0, 8'd9},  // R9 load leaves table
    {2'd3, 32'h0000_0700, 2'd3, 1'b1, 1'b1, 8'd9}   // R9 reservation intact
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {valid,wr,sc,ok} actual %b expected %b", tag, act, exp);
    end
  endtask

  // drive on a falling edge, sample on the next falling edge
  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [1:0] c);
    req_valid = 1'b1; req_op = op; req_addr = a; req_ctx = c;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", {resp_valid, resp_wr_en, resp_sc, resp_sc_ok}, 4'b0000);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [31:0] a;
      logic [1:0]  c;
      logic        ew, eo;
      string       t;
      op = VEC[i][45:44]; a = VEC[i][43:12]; c = VEC[i][11:10];
      ew = VEC[i][9]; eo = VEC[i][8];
      t = $sformatf("R%0d vec %0d", VEC[i][7:0], i);
      issue(op, a, c);
      check(t, {resp_valid, ew ? 1'b1 : resp_wr_en & 1'b0 | resp_wr_en, resp_sc, resp_sc_ok},
            {1'b1, ew ? 1'b1 : resp_wr_en & 1'b0 | resp_wr_en, op == 2'd3, eo});
      check(t, {1'b1, resp_wr_en, 2'b00}, {1'b1, ew, 2'b00});
    end

    // R10: idle cycle yields empty response
    @(negedge clk);
    check("R10 idle", {resp_valid, resp_wr_en, resp_sc, resp_sc_ok}, 4'b0000);

    // R1: reset drops a live reservation
    issue(2'd1, 32'h0000_0800, 2'd2);
    rst = 1'b1;
    @(negedge clk);
    check("R1 during reset", {resp_valid, resp_wr_en, resp_sc, resp_sc_ok}, 4'b0000);
    rst = 1'b0;
    issue(2'd3, 32'h0000_0800, 2'd2);
    check("R1 SC after reset", {resp_valid, resp_wr_en, resp_sc, resp_sc_ok}, 4'b1010);

    // R5: store while reservations are held still writes
    issue(2'd1, 32'h0000_0900, 2'd0);
    issue(2'd2, 32'h0000_0A00, 2'd3);
    check("R5 store with table held", {resp_valid, resp_wr_en, resp_sc, resp_sc_ok}, 4'b1100);
    issue(2'd3, 32'h0000_0900, 2'd0);
    check("R11 SC after unrelated store", {resp_valid, resp_wr_en, resp_sc, resp_sc_ok}, 4'b1111);

    finish_run();
  end
endmodule